// File: doc/BRIEF.md
# Test Pattern Receive Checker with Sync Acquisition and Error Counters

This block sits on the receive side of a bit-error-rate test path. It takes a serial bit stream qualified by a data-enable strobe and compares it with one of four test patterns: all zeros, all ones, or one of two pseudo-random sequences. It locks onto the incoming pattern without help. First it loads a local reference shift register directly from the received bits. Then it checks that the reference predicts a run of following bits correctly. Once locked, the reference runs free, so one corrupted line bit costs exactly one counted error.

While locked, the block counts every qualified bit and every mismatch. When too many errors fall inside one observation window, it declares loss of lock and goes back to seeding by itself. A latch pulse can be given at any moment during a test. The pulse copies both running counts to held outputs and restarts the running counts from zero, so statistics are available while the test keeps going. A sticky flag records any loss of lock since the last latch.

Top module: `bert_sync_checker`

## Requirements
- R1: `mode_i` selects the pattern to check: 0 = all zeros, 1 = all ones, 2 = sequence b[n] = b[n-9] xor b[n-5], 3 = sequence b[n] = b[n-15] xor b[n-14].
- R2: After reset or loss of lock, the block seeds its reference from N qualified bits (N = 9 for mode 2, 15 for mode 3, 1 for modes 0 and 1). It then needs 32 consecutive correctly predicted bits. `lock_o` rises on the clock edge that samples the 32nd of these bits.
- R3: The running bit count increases by one for each qualified bit sampled while already locked. Bits taken during seeding or verification are not counted.
- R4: Each qualified bit sampled while locked that differs from the free-running reference adds one to the running error count. A single inverted bit produces exactly one error.
- R5: A mismatch during verification, before lock, restarts seeding. Lock then needs N fresh seed bits plus 32 clean bits.
- R6: Lock is lost on the bit that brings the error total inside the current 64-bit window to 6. Windows are consecutive blocks of 64 locked bits, starting at lock entry. Five errors per window keep lock.
- R7: After loss of lock, the block re-acquires on its own when the stream is correct again, with no outside action.
- R8: A `latch_i` pulse copies the running bit and error counts to `bit_cnt_o` and `err_cnt_o` and clears the running counts. A bit counted in the latch cycle itself goes into the new period.
- R9: The running counts saturate at all ones and never wrap.
- R10: Input bits with `den_i` low are ignored. They affect neither the reference, the sync state nor the counts.
- R11: `loss_flag_o` is set when lock is lost and cleared by `latch_i`. A loss in the same cycle as a latch takes priority.
- R12: Reset clears `lock_o`, `loss_flag_o`, `bit_cnt_o` and `err_cnt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Pattern select (R1 encoding) |
| data_i | input | 1 | Received serial bit |
| den_i | input | 1 | Data-enable strobe; bit is sampled when high |
| latch_i | input | 1 | Latch-and-clear request for the counters |
| lock_o | output | 1 | Pattern lock state |
| loss_flag_o | output | 1 | Sticky loss-of-lock flag since last latch |
| bit_cnt_o | output | CNT_W | Held bit count from the last latch |
| err_cnt_o | output | CNT_W | Held error count from the last latch |

## Verification
The bench builds the checker with a counter width of 10 bits instead of 32. That makes saturation of the running counts reachable with about a thousand locked bits. The sync run length, window length and loss threshold stay at 32, 64 and 6. This keeps the exact bit on which lock rises or falls, and the five-errors-per-window tolerance, as they are in the default build.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;

  typedef enum logic [1:0] {
    MODE_ZEROS  = 2'd0,
    MODE_ONES   = 2'd1,
    MODE_PRBS9  = 2'd2,
    MODE_PRBS15 = 2'd3
  } pat_mode_e;

  typedef enum logic [1:0] {
    ST_SEED   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_SYNC   = 2'd2
  } sync_state_e;

  localparam int P9_LEN  = 9;
  localparam int P9_TAP  = 5;
  localparam int P15_LEN = 15;
  localparam int P15_TAP = 14;
  localparam int REF_W   = P15_LEN;
  localparam int SEED_W  = $clog2(REF_W + 1);

endpackage

// File: rtl/prx_predict.sv
module prx_predict
  import bert_rx_pkg::*;
(
  input  pat_mode_e          mode,
  input  logic [REF_W-1:0]   ref_q,
  output logic               pred,
  output logic [SEED_W-1:0]  seed_len
);

  always_comb begin
    unique case (mode)
      MODE_ZEROS: begin
        pred     = 1'b0;
        seed_len = SEED_W'(1);
      end
      MODE_ONES: begin
        pred     = 1'b1;
        seed_len = SEED_W'(1);
      end
      MODE_PRBS9: begin
        pred     = ref_q[P9_LEN-1] ^ ref_q[P9_TAP-1];
        seed_len = SEED_W'(P9_LEN);
      end
      default: begin
        pred     = ref_q[P15_LEN-1] ^ ref_q[P15_TAP-1];
        seed_len = SEED_W'(P15_LEN);
      end
    endcase
  end

endmodule

// File: rtl/prx_sync_fsm.sv
module prx_sync_fsm
  import bert_rx_pkg::*;
#(
  parameter int SYNC_RUN  = 32,
  parameter int LOSS_WIN  = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              mismatch,
  input  logic [SEED_W-1:0] seed_len,
  output sync_state_e       state,
  output logic              in_sync,
  output logic              lost_evt
);

  localparam int RUN_W = $clog2(SYNC_RUN + 1);
  localparam int WIN_W = $clog2(LOSS_WIN);
  localparam int ERR_W = $clog2(LOSS_ERRS + 1);

  logic [SEED_W-1:0] seed_cnt;
  logic [RUN_W-1:0]  run_cnt;
  logic [WIN_W-1:0]  win_cnt;
  logic [ERR_W-1:0]  win_errs;
  logic [ERR_W-1:0]  errs_next;

  assign errs_next = win_errs + {{(ERR_W-1){1'b0}}, mismatch};
  assign in_sync   = (state == ST_SYNC);
  assign lost_evt  = strobe && in_sync && (errs_next >= ERR_W'(LOSS_ERRS));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SEED;
      seed_cnt <= '0;
      run_cnt  <= '0;
      win_cnt  <= '0;
      win_errs <= '0;
    end else if (strobe) begin
      unique case (state)
        ST_SEED: begin
          if (seed_cnt == seed_len - SEED_W'(1)) begin
            state    <= ST_VERIFY;
            seed_cnt <= '0;
            run_cnt  <= '0;
          end else begin
            seed_cnt <= seed_cnt + SEED_W'(1);
          end
        end
        ST_VERIFY: begin
          if (mismatch) begin
            state    <= ST_SEED;
            seed_cnt <= '0;
          end else if (run_cnt == RUN_W'(SYNC_RUN - 1)) begin
            state    <= ST_SYNC;
            win_cnt  <= '0;
            win_errs <= '0;
          end else begin
            run_cnt <= run_cnt + RUN_W'(1);
          end
        end
        default: begin
          if (errs_next >= ERR_W'(LOSS_ERRS)) begin
            state    <= ST_SEED;
            seed_cnt <= '0;
          end else if (win_cnt == WIN_W'(LOSS_WIN - 1)) begin
            win_cnt  <= '0;
            win_errs <= '0;
          end else begin
            win_cnt  <= win_cnt + WIN_W'(1);
            win_errs <= errs_next;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/prx_sat_cnt.sv
module prx_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (clr) begin
      value <= inc ? W'(1) : '0;
    end else if (inc && (value != {W{1'b1}})) begin
      value <= value + W'(1);
    end
  end

endmodule

// File: rtl/bert_sync_checker.sv
module bert_sync_checker
  import bert_rx_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SYNC_RUN  = 32,
  parameter int LOSS_WIN  = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             data_i,
  input  logic             den_i,
  input  logic             latch_i,
  output logic             lock_o,
  output logic             loss_flag_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic [CNT_W-1:0] err_cnt_o
);

  logic [REF_W-1:0]  ref_q;
  logic              pred;
  logic [SEED_W-1:0] seed_len;
  logic              mismatch;
  sync_state_e       state;
  logic              in_sync;
  logic              lost_evt;
  logic              bit_inc;
  logic              err_inc;
  logic [CNT_W-1:0]  run_bits;
  logic [CNT_W-1:0]  run_errs;
  logic              sticky_q;

  prx_predict u_pred (
    .mode     (pat_mode_e'(mode_i)),
    .ref_q    (ref_q),
    .pred     (pred),
    .seed_len (seed_len)
  );

  assign mismatch = data_i ^ pred;

  prx_sync_fsm #(
    .SYNC_RUN  (SYNC_RUN),
    .LOSS_WIN  (LOSS_WIN),
    .LOSS_ERRS (LOSS_ERRS)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .strobe   (den_i),
    .mismatch (mismatch),
    .seed_len (seed_len),
    .state    (state),
    .in_sync  (in_sync),
    .lost_evt (lost_evt)
  );

  // Reference loads line bits while seeding, then runs on its own prediction.
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
    end else if (den_i) begin
      ref_q <= {ref_q[REF_W-2:0], (state == ST_SEED) ? data_i : pred};
    end
  end

  assign bit_inc = den_i && in_sync;
  assign err_inc = bit_inc && mismatch;

  prx_sat_cnt #(.W(CNT_W)) u_bits (
    .clk (clk), .rst (rst), .inc (bit_inc), .clr (latch_i), .value (run_bits)
  );

  prx_sat_cnt #(.W(CNT_W)) u_errs (
    .clk (clk), .rst (rst), .inc (err_inc), .clr (latch_i), .value (run_errs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt_o <= '0;
      err_cnt_o <= '0;
      sticky_q  <= 1'b0;
    end else begin
      if (latch_i) begin
        bit_cnt_o <= run_bits;
        err_cnt_o <= run_errs;
      end
      if (lost_evt) begin
        sticky_q <= 1'b1;
      end else if (latch_i) begin
        sticky_q <= 1'b0;
      end
    end
  end

  assign lock_o      = in_sync;
  assign loss_flag_o = sticky_q;

endmodule

// File: rtl/bert_sync_checker_sva.sv
module bert_sync_checker_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             den_i,
  input logic             latch_i,
  input logic             lock_o,
  input logic             loss_flag_o,
  input logic [CNT_W-1:0] bit_cnt_o,
  input logic [CNT_W-1:0] run_bits,
  input logic [CNT_W-1:0] run_errs
);

  p_no_count_unlocked_r3: assert property (@(posedge clk) disable iff (rst)
    (!lock_o && !latch_i) |=> $stable(run_bits));

  p_no_err_unlocked_r4: assert property (@(posedge clk) disable iff (rst)
    (!lock_o && !latch_i) |=> $stable(run_errs));

  p_errs_within_bits_r4: assert property (@(posedge clk) disable iff (rst)
    run_errs <= run_bits);

  p_latch_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (latch_i && !(den_i && lock_o)) |=> (run_bits == '0));

  p_latch_copies_r8: assert property (@(posedge clk) disable iff (rst)
    latch_i |=> (bit_cnt_o == $past(run_bits)));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    ((run_bits == {CNT_W{1'b1}}) && !latch_i) |=> (run_bits == {CNT_W{1'b1}}));

  p_loss_flags_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_o) |-> loss_flag_o);

endmodule

bind bert_sync_checker bert_sync_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .den_i       (den_i),
  .latch_i     (latch_i),
  .lock_o      (lock_o),
  .loss_flag_o (loss_flag_o),
  .bit_cnt_o   (bit_cnt_o),
  .run_bits    (run_bits),
  .run_errs    (run_errs)
);

// File: tb/bert_sync_checker_tb.sv
module bert_sync_checker_tb;

  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode_i = 2'd2;
  logic          data_i = 1'b0;
  logic          den_i = 1'b0;
  logic          latch_i = 1'b0;
  logic          lock_o;
  logic          loss_flag_o;
  logic [CW-1:0] bit_cnt_o;
  logic [CW-1:0] err_cnt_o;

  int tests = 0;
  int fails = 0;
  logic [14:0] hist;

  always #5 clk = ~clk;

  bert_sync_checker #(.CNT_W(CW)) u_dut (
    .clk (clk), .rst (rst), .mode_i (mode_i), .data_i (data_i),
    .den_i (den_i), .latch_i (latch_i), .lock_o (lock_o),
    .loss_flag_o (loss_flag_o), .bit_cnt_o (bit_cnt_o), .err_cnt_o (err_cnt_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic gen_next();
    logic b;
    case (mode_i)
      2'd0: b = 1'b0;
      2'd1: b = 1'b1;
      2'd2: b = hist[8] ^ hist[4];
      default: b = hist[14] ^ hist[13];
    endcase
    hist = {hist[13:0], b};
    return b;
  endfunction

  task automatic push(input logic b, input logic en);
    data_i = b;
    den_i  = en;
    @(negedge clk);
    den_i  = 1'b0;
  endtask

  task automatic good(input int n);
    for (int i = 0; i < n; i++) push(gen_next(), 1'b1);
  endtask

  task automatic bad();
    push(~gen_next(), 1'b1);
  endtask

  task automatic do_latch();
    latch_i = 1'b1;
    @(negedge clk);
    latch_i = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst = 1'b1;
    mode_i = m;
    hist = 15'h0001;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(2'd2);
    chk("R12 lock", lock_o, 0);
    chk("R12 flag", loss_flag_o, 0);
    chk("R12 bits", bit_cnt_o, 0);
    chk("R12 errs", err_cnt_o, 0);
  endtask

  task automatic t_acquire9();
    do_reset(2'd2);
    good(40);
    chk("R2 prbs9 no lock at 40", lock_o, 0);
    good(1);
    chk("R2 R1 prbs9 lock at 41", lock_o, 1);
  endtask

  task automatic t_counts();
    do_latch();
    chk("R3 verify bits uncounted", bit_cnt_o, 0);
    for (int i = 0; i < 100; i++) begin
      if (i == 10 || i == 20 || i == 30) bad(); else good(1);
    end
    do_latch();
    chk("R3 bits", bit_cnt_o, 100);
    chk("R4 errs", err_cnt_o, 3);
  endtask

  task automatic t_den_gap();
    for (int i = 0; i < 50; i++) begin
      good(1);
      push(i[0], 1'b0);
      push(~i[0], 1'b0);
    end
    do_latch();
    chk("R10 bits with gaps", bit_cnt_o, 50);
    chk("R10 no errs from gaps", err_cnt_o, 0);
    chk("R10 lock kept", lock_o, 1);
  endtask

  task automatic t_window_and_loss();
    do_reset(2'd2);
    good(41);
    do_latch();
    for (int w = 0; w < 2; w++) begin
      repeat (5) bad();
      good(59);
    end
    chk("R6 five per window keeps lock", lock_o, 1);
    do_latch();
    chk("R6 bits two windows", bit_cnt_o, 128);
    chk("R6 errs two windows", err_cnt_o, 10);
    chk("R11 no flag without loss", loss_flag_o, 0);
    repeat (5) bad();
    chk("R6 lock at 5 errors", lock_o, 1);
    bad();
    chk("R6 lock lost at 6th error", lock_o, 0);
    chk("R11 flag set on loss", loss_flag_o, 1);
    do_latch();
    chk("R8 bits at loss", bit_cnt_o, 6);
    chk("R8 errs at loss", err_cnt_o, 6);
    chk("R11 flag cleared by latch", loss_flag_o, 0);
    good(40);
    chk("R7 not yet relocked", lock_o, 0);
    good(1);
    chk("R7 relocked", lock_o, 1);
  endtask

  task automatic t_verify_restart();
    do_reset(2'd2);
    good(19);
    bad();
    good(40);
    chk("R5 no lock after restart", lock_o, 0);
    good(1);
    chk("R5 lock after full restart", lock_o, 1);
  endtask

  task automatic t_latch_same_cycle();
    do_latch();
    latch_i = 1'b1;
    good(1);
    latch_i = 1'b0;
    do_latch();
    chk("R8 latch-cycle bit in new period", bit_cnt_o, 1);
  endtask

  task automatic t_fixed();
    do_reset(2'd1);
    good(32);
    chk("R1 ones no lock at 32", lock_o, 0);
    good(1);
    chk("R1 R2 ones lock at 33", lock_o, 1);
    do_latch();
    push(1'b0, 1'b1);
    good(3);
    do_latch();
    chk("R1 ones zero is error", err_cnt_o, 1);
    do_reset(2'd0);
    good(33);
    chk("R1 zeros lock at 33", lock_o, 1);
  endtask

  task automatic t_prbs15();
    do_reset(2'd3);
    good(46);
    chk("R1 prbs15 no lock at 46", lock_o, 0);
    good(1);
    chk("R1 R2 prbs15 lock at 47", lock_o, 1);
  endtask

  task automatic t_saturate();
    do_reset(2'd2);
    good(41);
    do_latch();
    good(1100);
    do_latch();
    chk("R9 bits saturate", bit_cnt_o, (1 << CW) - 1);
    chk("R9 errs zero", err_cnt_o, 0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_acquire9();
    t_counts();
    t_den_gap();
    t_latch_same_cycle();
    t_window_and_loss();
    t_verify_restart();
    t_fixed();
    t_prbs15();
    t_saturate();
    finish_run();
  end

  initial begin
    #1_900_000;
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

endmodule